// File: doc/BRIEF.md
# Prefixed 8-bit Opcode Decoder

This block sits at the front of an 8-bit accumulator CPU and turns each opcode byte into a compact description of the instruction. The description gives an instruction class, the 8-bit destination and source operands, a register-pair selector, an operation or bit index, a branch condition and a restart vector. An upstream fetch stage presents one byte per cycle with `in_valid`. One cycle later the decoder raises `dec_strobe` with the registered description. All 256 byte values have a defined result. The eleven slots that the reduced instruction set leaves empty come out as class MISSING, with `dec_illegal` set and the byte copied to `dec_raw`.

Byte 0xCB is an escape. It produces no strobe and instead sets `prefix_pending`. The next valid byte is then decoded from a second map of rotate, shift, swap, bit-test, bit-clear and bit-set operations, and the pending flag drops. Cycles without `in_valid` leave the pending flag untouched. A synchronous reset clears the pending flag and the strobe.

Fields of a byte b: x=b[7:6], y=b[5:3], z=b[2:0], p=b[5:4], q=b[3]. Operand codes: 0..7 are the registers B,C,D,E,H,L,(HL),A in z/y order, 8 = 8-bit immediate, 9 = memory at a 16-bit immediate address, 10 = high page at an immediate offset, 11 = high page indexed by C, 12 = (BC), 13 = (DE), 14 = (HL) with post-increment, 15 = (HL) with post-decrement. Pair codes: 0 BC, 1 DE, 2 HL, 3 SP, 4 AF. Condition codes: 0 NZ, 1 Z, 2 NC, 3 C, 4 always. Any output field that a class does not name is 0.

Top module: `opbyte_decoder`

## Requirements
- R1: With x=1 the class is LD8 (3) with dst=y and src=z. The exception is byte 0x76, which is HALT (2).
- R2: With x=2 the class is ALU (12) with op=y and src=z. Bytes with x=3 and z=6 are ALU (12) with op=y and src=8.
- R3: With x=0 and z=0: y=0 gives NOP (0), y=1 gives STSP (5, store SP to an immediate address), y=2 gives STOP (1), and y=3..7 give JR (14). For JR, cond=4 when y=3, otherwise cond=y-4.
- R4: With x=3 and z=0: y=0..3 give RET (18) with cond=y. y=4 gives LD8 with dst=10, src=7. y=5 gives ADDSP (25). y=6 gives LD8 with dst=7, src=10. y=7 gives LDHLSP (26).
- R5: With x=3 and z=2: y=0..3 give JP (15) with cond=y. y=4..7 give LD8 with (dst,src) equal to (11,7), (9,7), (7,11) and (7,9) in that order.
- R6: Bytes 0xD3, 0xDB, 0xE3, 0xEB, 0xE4, 0xEC, 0xF4, 0xFC, 0xDD, 0xED and 0xFD give MISSING (27) with `dec_illegal`=1. `dec_illegal` is 0 for every other byte. `dec_raw` always equals the decoded byte.
- R7: With x=3 and z=7 the class is RST (20) with vector y*8.
- R8: With x=3 and z=1: q=0 gives POP (22) with pair=p, where p=3 maps to AF (4). With q=1, p=0..3 give RET with cond=4, RETI (19), JPHL (16) and LDSPHL (6).
- R9: A valid 0xCB while no prefix is pending gives no strobe and sets `prefix_pending`. The next valid byte is strobed with `dec_prefixed`=1, dst=z and op=y, and it clears the flag. Its class comes from x: SHIFT (28), BITT (29), BITR (30) or BITS (31). A 0xCB arriving while the flag is set is decoded as an ordinary prefixed byte. Invalid cycles do not change the flag.
- R10: `dec_strobe` is high exactly in the cycle after a valid byte other than a prefix-starting 0xCB, and is low otherwise.
- R11: A synchronous reset clears `prefix_pending` and `dec_strobe`, even when a valid byte arrives in the same cycle.
- R12: With x=0 and z=1..7: z=1 gives LD16I (4) when q=0 and ADD16 (11) when q=1, with pair=p. z=3 gives INC16 (9) when q=0 and DEC16 (10) when q=1, with pair=p. z=2 gives LD8 with dst=12+p, src=7 when q=0, and dst=7, src=12+p when q=1. z=4 gives INC8 (7) with dst=y. z=5 gives DEC8 (8) with dst=y. z=6 gives LD8 with dst=y, src=8. z=7 gives ALU1 (13) with op=y.
- R13: With x=3: byte 0xC3 gives JP with cond=4. 0xF3 gives DI (23) and 0xFB gives EI (24). z=4 with y=0..3 gives CALL (17) with cond=y. z=5 with q=0 gives PUSH (21) with pair=p, where p=3 maps to AF (4). Byte 0xCD gives CALL with cond=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Opcode byte present |
| in_byte | input | 8 | Opcode byte |
| dec_strobe | output | 1 | Decoded instruction valid this cycle |
| dec_class | output | 5 | Instruction class code |
| dec_illegal | output | 1 | Byte is an empty slot |
| dec_prefixed | output | 1 | Byte was decoded from the escape map |
| dec_raw | output | 8 | The decoded byte |
| dec_dst | output | 4 | 8-bit destination operand code |
| dec_src | output | 4 | 8-bit source operand code |
| dec_pair | output | 3 | Register pair code |
| dec_op | output | 3 | ALU, unary, shift operation or bit index |
| dec_cond | output | 3 | Branch condition code |
| dec_vec | output | 8 | Restart vector |
| prefix_pending | output | 1 | Escape byte seen, next byte is prefixed |

## Verification
Two of the block's functions can land in the same cycle. One pair is prefix tracking and ordinary decoding: a 0xCB that arrives while a prefix is already pending must be decoded as bit-set 1 on E and must not open a new prefix. The other pair is reset and a valid byte: reset has to win and leave no strobe and no pending flag. The bench drives back-to-back 0xCB pairs and asserts reset together with a valid byte while a prefix is open. It judges the outcome from the strobe and the pending flag in the following cycle, and runs a random stream with a heavy share of 0xCB bytes and idle cycles against a reference function.

// File: rtl/opbyte_decoder.sv
module opbyte_decoder #(
  parameter int W = 8,
  parameter logic [7:0] ESC = 8'hCB
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_byte,
  output logic         dec_strobe,
  output logic [4:0]   dec_class,
  output logic         dec_illegal,
  output logic         dec_prefixed,
  output logic [W-1:0] dec_raw,
  output logic [3:0]   dec_dst,
  output logic [3:0]   dec_src,
  output logic [2:0]   dec_pair,
  output logic [2:0]   dec_op,
  output logic [2:0]   dec_cond,
  output logic [7:0]   dec_vec,
  output logic         prefix_pending
);
  localparam logic [4:0] C_NOP = 5'd0, C_STOP = 5'd1, C_HALT = 5'd2, C_LD8 = 5'd3,
    C_LD16I = 5'd4, C_STSP = 5'd5, C_LDSPHL = 5'd6, C_INC8 = 5'd7, C_DEC8 = 5'd8,
    C_INC16 = 5'd9, C_DEC16 = 5'd10, C_ADD16 = 5'd11, C_ALU = 5'd12, C_ALU1 = 5'd13,
    C_JR = 5'd14, C_JP = 5'd15, C_JPHL = 5'd16, C_CALL = 5'd17, C_RET = 5'd18,
    C_RETI = 5'd19, C_RST = 5'd20, C_PUSH = 5'd21, C_POP = 5'd22, C_DI = 5'd23,
    C_EI = 5'd24, C_ADDSP = 5'd25, C_LDHLSP = 5'd26, C_MISS = 5'd27,
    C_SHIFT = 5'd28, C_BITT = 5'd29, C_BITR = 5'd30, C_BITS = 5'd31;
  localparam logic [3:0] O_A = 4'd7, O_IMM = 4'd8, O_ABS = 4'd9, O_HIMM = 4'd10,
    O_HC = 4'd11, O_IND = 4'd12;
  localparam logic [2:0] P_AF = 3'd4, CC_ALL = 3'd4;

  logic [1:0] x, p;
  logic [2:0] y, z;
  logic       q;
  assign x = in_byte[7:6];
  assign y = in_byte[5:3];
  assign z = in_byte[2:0];
  assign p = in_byte[5:4];
  assign q = in_byte[3];

  logic       esc_hit, emit;
  assign esc_hit = in_valid && !prefix_pending && (in_byte == ESC);
  assign emit    = in_valid && !esc_hit;

  logic [4:0] n_cls;
  logic [3:0] n_dst, n_src;
  logic [2:0] n_pair, n_op, n_cond;
  logic [7:0] n_vec;
  logic [2:0] pair_af;
  assign pair_af = (p == 2'd3) ? P_AF : {1'b0, p};

  always_comb begin
    n_cls = C_NOP; n_dst = '0; n_src = '0; n_pair = '0;
    n_op = '0; n_cond = '0; n_vec = '0;
    if (prefix_pending) begin
      n_dst = {1'b0, z};
      n_op  = y;
      case (x)
        2'd0: n_cls = C_SHIFT;
        2'd1: n_cls = C_BITT;
        2'd2: n_cls = C_BITR;
        default: n_cls = C_BITS;
      endcase
    end else begin
      case (x)
        2'd0: begin
          case (z)
            3'd0: begin
              case (y)
                3'd0: n_cls = C_NOP;
                3'd1: n_cls = C_STSP;
                3'd2: n_cls = C_STOP;
                default: begin
                  n_cls  = C_JR;
                  n_cond = (y == 3'd3) ? CC_ALL : {1'b0, y[1:0]};
                end
              endcase
            end
            3'd1: begin
              n_cls  = q ? C_ADD16 : C_LD16I;
              n_pair = {1'b0, p};
            end
            3'd2: begin
              n_cls = C_LD8;
              if (q) begin
                n_dst = O_A; n_src = O_IND + {2'b0, p};
              end else begin
                n_dst = O_IND + {2'b0, p}; n_src = O_A;
              end
            end
            3'd3: begin
              n_cls  = q ? C_DEC16 : C_INC16;
              n_pair = {1'b0, p};
            end
            3'd4: begin n_cls = C_INC8; n_dst = {1'b0, y}; end
            3'd5: begin n_cls = C_DEC8; n_dst = {1'b0, y}; end
            3'd6: begin n_cls = C_LD8; n_dst = {1'b0, y}; n_src = O_IMM; end
            default: begin n_cls = C_ALU1; n_op = y; end
          endcase
        end
        2'd1: begin
          if (y == 3'd6 && z == 3'd6) n_cls = C_HALT;
          else begin
            n_cls = C_LD8; n_dst = {1'b0, y}; n_src = {1'b0, z};
          end
        end
        2'd2: begin
          n_cls = C_ALU; n_op = y; n_src = {1'b0, z};
        end
        default: begin
          case (z)
            3'd0: begin
              if (!y[2]) begin
                n_cls = C_RET; n_cond = {1'b0, y[1:0]};
              end else begin
                case (y[1:0])
                  2'd0: begin n_cls = C_LD8; n_dst = O_HIMM; n_src = O_A; end
                  2'd1: n_cls = C_ADDSP;
                  2'd2: begin n_cls = C_LD8; n_dst = O_A; n_src = O_HIMM; end
                  default: n_cls = C_LDHLSP;
                endcase
              end
            end
            3'd1: begin
              if (!q) begin
                n_cls = C_POP; n_pair = pair_af;
              end else begin
                case (p)
                  2'd0: begin n_cls = C_RET; n_cond = CC_ALL; end
                  2'd1: n_cls = C_RETI;
                  2'd2: n_cls = C_JPHL;
                  default: n_cls = C_LDSPHL;
                endcase
              end
            end
            3'd2: begin
              if (!y[2]) begin
                n_cls = C_JP; n_cond = {1'b0, y[1:0]};
              end else begin
                n_cls = C_LD8;
                case (y[1:0])
                  2'd0: begin n_dst = O_HC;  n_src = O_A; end
                  2'd1: begin n_dst = O_ABS; n_src = O_A; end
                  2'd2: begin n_dst = O_A;   n_src = O_HC; end
                  default: begin n_dst = O_A; n_src = O_ABS; end
                endcase
              end
            end
            3'd3: begin
              case (y)
                3'd0: begin n_cls = C_JP; n_cond = CC_ALL; end
                3'd1: n_cls = C_NOP;
                3'd6: n_cls = C_DI;
                3'd7: n_cls = C_EI;
                default: n_cls = C_MISS;
              endcase
            end
            3'd4: begin
              if (!y[2]) begin
                n_cls = C_CALL; n_cond = {1'b0, y[1:0]};
              end else n_cls = C_MISS;
            end
            3'd5: begin
              if (!q) begin
                n_cls = C_PUSH; n_pair = pair_af;
              end else if (p == 2'd0) begin
                n_cls = C_CALL; n_cond = CC_ALL;
              end else n_cls = C_MISS;
            end
            3'd6: begin n_cls = C_ALU; n_op = y; n_src = O_IMM; end
            default: begin n_cls = C_RST; n_vec = {2'b0, y, 3'b0}; end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prefix_pending <= 1'b0;
      dec_strobe     <= 1'b0;
      dec_class      <= C_NOP;
      dec_illegal    <= 1'b0;
      dec_prefixed   <= 1'b0;
      dec_raw        <= '0;
      dec_dst        <= '0;
      dec_src        <= '0;
      dec_pair       <= '0;
      dec_op         <= '0;
      dec_cond       <= '0;
      dec_vec        <= '0;
    end else begin
      dec_strobe <= emit;
      if (esc_hit) prefix_pending <= 1'b1;
      else if (in_valid) prefix_pending <= 1'b0;
      if (emit) begin
        dec_class    <= n_cls;
        dec_illegal  <= !prefix_pending && (n_cls == C_MISS);
        dec_prefixed <= prefix_pending;
        dec_raw      <= in_byte;
        dec_dst      <= n_dst;
        dec_src      <= n_src;
        dec_pair     <= n_pair;
        dec_op       <= n_op;
        dec_cond     <= n_cond;
        dec_vec      <= n_vec;
      end
    end
  end

  AST_ESC_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefix_pending && in_byte == ESC) |=> (!dec_strobe && prefix_pending)); // R9
  AST_ESC_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && prefix_pending) |=> (dec_strobe && dec_prefixed && !prefix_pending)); // R9
  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prefix_pending)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !dec_strobe); // R10
  AST_HALT_SLOT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefix_pending && in_byte == 8'h76) |=> (dec_class == C_HALT)); // R1
  AST_ILLEGAL_MATCH: assert property (@(posedge clk) disable iff (rst)
    dec_strobe |-> (dec_illegal == (dec_class == C_MISS))); // R6
  AST_RAW_ECHO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(in_byte == ESC && !prefix_pending)) |=> (dec_raw == $past(in_byte))); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!dec_strobe && !prefix_pending)); // R11
endmodule

// File: tb/sim_opbyte_decoder.sv
module sim_opbyte_decoder;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic dec_strobe, dec_illegal, dec_prefixed, prefix_pending;
  logic [4:0] dec_class;
  logic [7:0] dec_raw, dec_vec;
  logic [3:0] dec_dst, dec_src;
  logic [2:0] dec_pair, dec_op, dec_cond;
  int checks = 0, errors = 0;
  bit mpend = 1'b0;

  always #2 clk = ~clk;

  opbyte_decoder u0 (.clk, .rst, .in_valid, .in_byte, .dec_strobe, .dec_class,
    .dec_illegal, .dec_prefixed, .dec_raw, .dec_dst, .dec_src, .dec_pair, .dec_op,
    .dec_cond, .dec_vec, .prefix_pending);

  // {class, illegal, prefixed, raw, dst, src, pair, op, cond, vec}
  function automatic logic [39:0] model(logic [7:0] b, bit pre);
    logic [4:0] c = 0; logic il = 0; logic [3:0] d = 0, s = 0;
    logic [2:0] pr = 0, o = 0, cc = 0; logic [7:0] v = 0;
    logic [2:0] y = b[5:3], z = b[2:0]; logic [1:0] p = b[5:4];
    logic [2:0] pa = (b[5:4] == 2'd3) ? 3'd4 : {1'b0, b[5:4]};
    if (pre) begin
      c = 5'd28 + {3'b0, b[7:6]}; d = {1'b0, z}; o = y;
    end else if (b inside {8'hD3, 8'hDB, 8'hE3, 8'hEB, 8'hE4, 8'hEC, 8'hF4, 8'hFC,
                           8'hDD, 8'hED, 8'hFD}) begin
      c = 27; il = 1;
    end else if (b == 8'h76) c = 2;
    else if (b[7:6] == 2'd1) begin c = 3; d = {1'b0, y}; s = {1'b0, z}; end
    else if (b[7:6] == 2'd2) begin c = 12; o = y; s = {1'b0, z}; end
    else if (b[7:6] == 2'd3 && z == 6) begin c = 12; o = y; s = 8; end
    else if (b[7:6] == 2'd3 && z == 7) begin c = 20; v = {2'b0, y, 3'b0}; end
    else if (b == 8'h00) c = 0;
    else if (b == 8'h08) c = 5;
    else if (b == 8'h10) c = 1;
    else if (b[7:6] == 0 && z == 0) begin c = 14; cc = (y == 3) ? 3'd4 : y - 3'd4; end
    else if (b[7:6] == 0 && z == 1) begin c = b[3] ? 5'd11 : 5'd4; pr = {1'b0, p}; end
    else if (b[7:6] == 0 && z == 3) begin c = b[3] ? 5'd10 : 5'd9; pr = {1'b0, p}; end
    else if (b[7:6] == 0 && z == 2) begin
      c = 3;
      if (b[3]) begin d = 7; s = 4'd12 + {2'b0, p}; end
      else begin d = 4'd12 + {2'b0, p}; s = 7; end
    end
    else if (b[7:6] == 0 && z == 4) begin c = 7; d = {1'b0, y}; end
    else if (b[7:6] == 0 && z == 5) begin c = 8; d = {1'b0, y}; end
    else if (b[7:6] == 0 && z == 6) begin c = 3; d = {1'b0, y}; s = 8; end
    else if (b[7:6] == 0) begin c = 13; o = y; end
    else begin
      case (b)
        8'hE0: begin c = 3; d = 10; s = 7; end
        8'hE8: c = 25;
        8'hF0: begin c = 3; d = 7; s = 10; end
        8'hF8: c = 26;
        8'hC9: begin c = 18; cc = 4; end
        8'hD9: c = 19;
        8'hE9: c = 16;
        8'hF9: c = 6;
        8'hE2: begin c = 3; d = 11; s = 7; end
        8'hEA: begin c = 3; d = 9; s = 7; end
        8'hF2: begin c = 3; d = 7; s = 11; end
        8'hFA: begin c = 3; d = 7; s = 9; end
        8'hC3: begin c = 15; cc = 4; end
        8'hCD: begin c = 17; cc = 4; end
        8'hF3: c = 23;
        8'hFB: c = 24;
        default: begin
          if (z == 0) begin c = 18; cc = y; end
          else if (z == 2) begin c = 15; cc = y; end
          else if (z == 4) begin c = 17; cc = y; end
          else if (z == 1) begin c = 22; pr = pa; end
          else if (z == 5) begin c = 21; pr = pa; end
        end
      endcase
    end
    return {c, il, pre, b, d, s, pr, o, cc, v};
  endfunction

  function automatic string tag(logic [7:0] b, bit pre);
    if (pre) return "R9";
    if (b inside {8'hD3, 8'hDB, 8'hE3, 8'hEB, 8'hE4, 8'hEC, 8'hF4, 8'hFC, 8'hDD, 8'hED, 8'hFD})
      return "R6";
    case (b[7:6])
      2'd1: return "R1";
      2'd2: return "R2";
      2'd0: return (b[2:0] == 0) ? "R3" : "R12";
      default: case (b[2:0])
        3'd0: return "R4";
        3'd1: return "R8";
        3'd2: return "R5";
        3'd6: return "R2";
        3'd7: return "R7";
        default: return "R13";
      endcase
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; drives for one cycle and checks at the next negedge
  task automatic step(bit v, logic [7:0] b);
    bit was = mpend, strobe;
    logic [39:0] exp, act;
    in_valid = v; in_byte = b;
    strobe = v && !(!was && b == 8'hCB);
    exp = model(b, was);
    if (v) mpend = was ? 1'b0 : (b == 8'hCB);
    @(negedge clk);
    chk(dec_strobe == strobe, "R10", "strobe", {39'b0, dec_strobe}, {39'b0, strobe});
    chk(prefix_pending == mpend, "R9", "pending", {39'b0, prefix_pending}, {39'b0, mpend});
    if (strobe) begin
      act = {dec_class, dec_illegal, dec_prefixed, dec_raw, dec_dst, dec_src,
             dec_pair, dec_op, dec_cond, dec_vec};
      chk(act == exp, tag(b, was), "decode", act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] act;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk(!dec_strobe && !prefix_pending, "R11", "reset state",
        {38'b0, dec_strobe, prefix_pending}, 40'd0);
    // full unprefixed and prefixed sweeps
    for (int i = 0; i < 256; i++) if (i != 8'hCB) step(1'b1, i[7:0]);
    for (int i = 0; i < 256; i++) begin step(1'b1, 8'hCB); step(1'b1, i[7:0]); end
    // directed corners
    step(1'b1, 8'h76);
    chk(dec_class == 5'd2, "R1", "halt slot", {35'b0, dec_class}, 40'd2);
    step(1'b0, 8'hCB);
    chk(!prefix_pending, "R9", "invalid escape ignored", {39'b0, prefix_pending}, 40'd0);
    step(1'b1, 8'hCB); step(1'b0, 8'h00); step(1'b0, 8'hCB); step(1'b1, 8'hCB);
    act = {dec_class, dec_op, dec_dst, 28'b0};
    chk(act == {5'd31, 3'd1, 4'd3, 28'b0}, "R9", "escape after escape", act,
        {5'd31, 3'd1, 4'd3, 28'b0});
    step(1'b1, 8'hDD);
    chk(dec_illegal && dec_raw == 8'hDD, "R6", "missing slot",
        {31'b0, dec_illegal, dec_raw}, {31'b0, 1'b1, 8'hDD});
    step(1'b1, 8'hFF);
    chk(dec_vec == 8'h38, "R7", "restart vector", {32'b0, dec_vec}, 40'h38);
    // reset colliding with a valid byte while a prefix is open
    step(1'b1, 8'hCB);
    rst = 1'b1; in_valid = 1'b1; in_byte = 8'h3C;
    @(negedge clk);
    rst = 1'b0; mpend = 1'b0;
    chk(!dec_strobe && !prefix_pending, "R11", "reset beats byte",
        {38'b0, dec_strobe, prefix_pending}, 40'd0);
    // random stream with heavy escape share
    for (int k = 0; k < 4000; k++) begin
      bit v = ($urandom % 10) < 7;
      logic [7:0] b = (($urandom % 6) == 0) ? 8'hCB : 8'($urandom);
      step(v, b);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule